// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block sits between a DMA engine's completion events for one transfer direction and the interrupt cause logic. It holds back the done interrupt so that several completions can be serviced by one interrupt. Two timers decide when the held interrupt is released. A burst timer caps how long the first unserviced completion may wait. An idle timer releases the interrupt once completions stop arriving for a set gap. Each timer counts either core clock cycles or pulses of an external 1 µs tick, so its threshold can be given in microseconds.

Software programs each timer through a small write port. The safe reconfiguration sequence is: clear the timer, load a new threshold, then enable it, with tick selection set as required. A ring-nearly-full indication is not delayed. It is passed straight through on its own output, because holding it back could let the ring overflow. With both timers disabled, every completion produces a done pulse at once.

Top module: `cmpl_irq_moderator`

## Requirements
- R1: After reset, done_o and ring_hi_o are low, both timers are disabled with zero thresholds, and no completion is pending.
- R2: A write with wr_en high updates one register at that clock edge, selected by wr_addr: 0 = burst control, 1 = burst threshold, 2 = idle control, 3 = idle threshold. Control data bit 0 is clear, bit 1 is enable and bit 2 is tick select.
- R3: While both timers are disabled, a completion on cmpl_evt_i gives a one-cycle done_o in the cycle after the completion edge.
- R4: With the burst timer enabled and threshold T > 0, done_o appears T counting steps after the completion that started the pending window. Further completions inside the window do not delay it.
- R5: With the idle timer enabled and threshold T > 0, every completion restarts the count, and done_o appears T counting steps after the last completion.
- R6: With both timers enabled, done_o is emitted by whichever timer reaches its threshold first.
- R7: With tick select clear, a timer advances on every clock. With tick select set, it advances only on clocks where us_tick_i is high.
- R8: An enabled timer whose threshold is zero makes a completion produce done_o in the cycle after the completion edge.
- R9: A control write with the clear bit set disables that timer and zeroes its count, even if the enable bit is also set. If this leaves no timer enabled while a completion is pending, done_o is emitted one cycle after the write edge.
- R10: Each done_o emission zeroes both counts and the pending state, so the next completion opens a fresh window with the full threshold.
- R11: ring_hi_o repeats ring_hi_i one cycle later. It does not change the pending state, the counts or done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick_i | input | 1 | External 1 µs tick pulse |
| cmpl_evt_i | input | 1 | Completion event pulse from the DMA engine |
| ring_hi_i | input | 1 | Ring-nearly-full indication, not moderated |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (R2) |
| wr_data | input | THR_W | Write data: threshold value or control bits |
| done_o | output | 1 | Moderated done interrupt pulse |
| ring_hi_o | output | 1 | Ring-nearly-full cause, delayed one cycle |

## Verification
The embedded assertions check, on every cycle, the properties that depend on one or two cycles of state. A completion with moderation off or a zero threshold must give done in the next cycle. A done pulse must leave nothing pending. Any timer hit, clear write or idle restart must leave a zeroed count. Every done must trace back to a completion or a pending window. The exact release cycle can only be shown by the directed scenarios, because it depends on a threshold count built up over many cycles. The scenarios cover burst and idle timing, the race between the two timers, tick-gated counting, the clear-and-reload sequence, and ring_hi passing through without disturbing a pending window.

// File: rtl/cim_pkg.sv
package cim_pkg;

  typedef enum logic [1:0] {
    REG_BURST_CTL = 2'd0,
    REG_BURST_THR = 2'd1,
    REG_IDLE_CTL  = 2'd2,
    REG_IDLE_THR  = 2'd3
  } reg_sel_e;

  localparam int CTL_CLR_BIT  = 0;
  localparam int CTL_EN_BIT   = 1;
  localparam int CTL_TSEL_BIT = 2;
  localparam int CTL_W        = 3;

  typedef struct packed {
    logic en;
    logic tsel;
  } tmr_ctl_t;

  // Clear wins over enable: a control write carrying clear leaves the timer off.
  function automatic tmr_ctl_t decode_ctl(input logic [CTL_W-1:0] v);
    tmr_ctl_t c;
    c.en   = v[CTL_EN_BIT] & ~v[CTL_CLR_BIT];
    c.tsel = v[CTL_TSEL_BIT];
    return c;
  endfunction

endpackage

// File: rtl/cim_regs.sv
module cim_regs
  import cim_pkg::*;
#(
  parameter int THR_W   = 16,
  parameter int NUM_TMR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [THR_W-1:0] wr_data,
  output tmr_ctl_t         ctl_o [NUM_TMR],
  output logic [THR_W-1:0] thr_o [NUM_TMR],
  output logic [NUM_TMR-1:0] clr_o
);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [1:0] CTL_A = 2'(2 * i);
    localparam logic [1:0] THR_A = 2'(2 * i + 1);

    tmr_ctl_t         ctl_r;
    logic [THR_W-1:0] thr_r;
    logic             ctl_wr;

    assign ctl_wr   = wr_en && (wr_addr == CTL_A);
    assign clr_o[i] = ctl_wr && wr_data[CTL_CLR_BIT];
    assign ctl_o[i] = ctl_r;
    assign thr_o[i] = thr_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_r <= '0;
        thr_r <= '0;
      end else begin
        if (ctl_wr) ctl_r <= decode_ctl(wr_data[CTL_W-1:0]);
        if (wr_en && (wr_addr == THR_A)) thr_r <= wr_data;
      end
    end

    AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o[i] |=> !ctl_r.en); // R9
  end

endmodule

// File: rtl/cim_timer.sv
module cim_timer
  import cim_pkg::*;
#(
  parameter int THR_W          = 16,
  parameter bit RESTART_ON_EVT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_ctl_t         ctl,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  input  logic             us_tick,
  input  logic             evt,
  input  logic             pend,
  input  logic             fire,
  output logic             hit
);

  // True when one more step brings the count to the threshold.
  function automatic logic reached(input logic [THR_W-1:0] c, input logic [THR_W-1:0] t);
    return ({1'b0, c} + (THR_W+1)'(1)) >= {1'b0, t};
  endfunction

  logic [THR_W-1:0] cnt_q;
  logic             step;
  logic             restart;
  logic             zero_hit;
  logic             run_hit;

  assign step     = ctl.tsel ? us_tick : 1'b1;
  assign restart  = RESTART_ON_EVT ? evt : 1'b0;
  assign zero_hit = ctl.en && evt && (thr == '0);
  assign run_hit  = ctl.en && pend && step && !restart && reached(cnt_q, thr);
  assign hit      = zero_hit || run_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || fire || !pend || !ctl.en || restart) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HIT_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0)); // R10
  AST_CLR_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R9

  if (RESTART_ON_EVT) begin : g_restart_chk
    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (cnt_q == '0)); // R5
  end

endmodule

// File: rtl/cmpl_irq_moderator.sv
module cmpl_irq_moderator
  import cim_pkg::*;
#(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick_i,
  input  logic             cmpl_evt_i,
  input  logic             ring_hi_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [THR_W-1:0] wr_data,
  output logic             done_o,
  output logic             ring_hi_o
);

  localparam int NUM_TMR = 2;
  localparam int BURST   = 0;
  localparam int IDLE    = 1;

  tmr_ctl_t           ctl   [NUM_TMR];
  logic [THR_W-1:0]   thr   [NUM_TMR];
  logic [NUM_TMR-1:0] clr;
  logic [NUM_TMR-1:0] hit;
  logic [NUM_TMR-1:0] en_vec;

  logic pend_q;
  logic mod_active;
  logic fire;
  logic done_q;
  logic ring_hi_q;

  cim_regs #(.THR_W(THR_W), .NUM_TMR(NUM_TMR)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl_o   (ctl),
    .thr_o   (thr),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_timer
    assign en_vec[i] = ctl[i].en;
    cim_timer #(.THR_W(THR_W), .RESTART_ON_EVT(i == IDLE)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl[i]),
      .thr     (thr[i]),
      .clr     (clr[i]),
      .us_tick (us_tick_i),
      .evt     (cmpl_evt_i),
      .pend    (pend_q),
      .fire    (fire),
      .hit     (hit[i])
    );
  end

  assign mod_active = |en_vec;
  assign fire       = (!mod_active && (cmpl_evt_i || pend_q)) || (|hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      ring_hi_q <= 1'b0;
    end else begin
      done_q    <= fire;
      ring_hi_q <= ring_hi_i;
      if (fire)            pend_q <= 1'b0;
      else if (cmpl_evt_i) pend_q <= 1'b1;
    end
  end

  assign done_o    = done_q;
  assign ring_hi_o = ring_hi_q;

  AST_BYPASS_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_evt_i && !mod_active) |=> done_o); // R3
  AST_ZERO_THR_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_evt_i && ctl[BURST].en && (thr[BURST] == '0)) |=> done_o); // R8
  AST_DONE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pend_q); // R10
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pend_q || cmpl_evt_i)); // R4

endmodule

// File: tb/cmpl_irq_moderator_bench.sv
module cmpl_irq_moderator_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  THR_W      = 16;
  localparam int  WATCHDOG   = 200000;

  localparam logic [1:0] A_BCTL = 2'd0, A_BTHR = 2'd1, A_ICTL = 2'd2, A_ITHR = 2'd3;
  localparam logic [THR_W-1:0] C_CLR = 16'h0001, C_EN = 16'h0002, C_EN_TICK = 16'h0006, C_CLR_EN = 16'h0003;

  logic clk = 1'b0;
  logic rst_n, us_tick, cmpl, ring_hi, wr_en;
  logic [1:0] wr_addr;
  logic [THR_W-1:0] wr_data;
  logic done_o, ring_hi_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpl_irq_moderator #(.THR_W(THR_W)) u_cmpl_irq_moderator (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .cmpl_evt_i(cmpl),
    .ring_hi_i(ring_hi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_o(done_o), .ring_hi_o(ring_hi_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [THR_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Step n drives ev[n]/tk[n] ahead of edge n; returns the first step whose edge shows done_o.
  task automatic run(input logic [31:0] ev, input logic [31:0] tk, input int maxn, output int got);
    got = -1;
    for (int n = 0; n <= maxn && got < 0; n++) begin
      @(negedge clk); cmpl = ev[n]; us_tick = tk[n];
      @(posedge clk); #1;
      if (done_o) got = n;
    end
    @(negedge clk); cmpl = 1'b0; us_tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 done_o after reset", int'(done_o), 0);
    chk("R1 ring_hi_o after reset", int'(ring_hi_o), 0);
  endtask

  task automatic t_immediate;
    int g;
    run(32'h1, 32'h0, 4, g);
    chk("R1 R3 disabled timers give immediate done", g, 0);
  endtask

  task automatic t_burst;
    int g;
    wr(A_ICTL, C_CLR); wr(A_BCTL, C_CLR); wr(A_BTHR, 16'd5); wr(A_BCTL, C_EN);
    run(32'b1101, 32'h0, 12, g);
    chk("R4 burst not extended by later completions", g, 5);
    run(32'h1, 32'h0, 12, g);
    chk("R10 fresh burst window after done", g, 5);
  endtask

  task automatic t_idle;
    int g;
    wr(A_BCTL, C_CLR); wr(A_ITHR, 16'd4); wr(A_ICTL, C_EN);
    run(32'h55, 32'h0, 20, g);
    chk("R5 idle restarts on each completion", g, 10);
  endtask

  task automatic t_both;
    int g;
    wr(A_BTHR, 16'd7); wr(A_BCTL, C_EN);
    run(32'h5555, 32'h0, 20, g);
    chk("R6 burst wins while completions keep coming", g, 7);
    run(32'h1, 32'h0, 20, g);
    chk("R6 idle wins after a single completion", g, 4);
  endtask

  task automatic t_tick;
    int g;
    wr(A_ICTL, C_CLR); wr(A_BCTL, C_CLR); wr(A_BTHR, 16'd3); wr(A_BCTL, C_EN_TICK);
    run(32'h1, 32'h1110, 20, g);
    chk("R7 counts only tick cycles", g, 12);
  endtask

  task automatic t_zero;
    int g;
    wr(A_BCTL, C_CLR); wr(A_BTHR, 16'd0); wr(A_BCTL, C_EN);
    run(32'h1, 32'h0, 6, g);
    chk("R8 zero threshold is immediate", g, 0);
  endtask

  task automatic t_clear;
    int g;
    wr(A_BCTL, C_CLR); wr(A_BTHR, 16'd20); wr(A_BCTL, C_EN);
    run(32'h1, 32'h0, 3, g);
    chk("R9 no early done before clear", g, -1);
    wr(A_BCTL, C_CLR_EN);
    @(posedge clk); #1;
    chk("R9 clear with pending flushes done", int'(done_o), 1);
    @(posedge clk); #1;
    chk("R9 flush is a single pulse", int'(done_o), 0);
    wr(A_BTHR, 16'd6); wr(A_BCTL, C_EN);
    run(32'h1, 32'h0, 12, g);
    chk("R2 R9 reload after clear uses new threshold", g, 6);
  endtask

  task automatic t_ring_hi;
    int g;
    wr(A_BTHR, 16'd8);
    @(negedge clk); ring_hi = 1'b1;
    @(posedge clk); #1;
    chk("R11 ring_hi passes after one cycle", int'(ring_hi_o), 1);
    chk("R11 ring_hi does not raise done", int'(done_o), 0);
    @(negedge clk); ring_hi = 1'b0;
    @(posedge clk); #1;
    chk("R11 ring_hi_o falls after input", int'(ring_hi_o), 0);
    chk("R11 no done after ring_hi", int'(done_o), 0);
    run(32'h1, 32'h0, 12, g);
    chk("R11 burst timing unaffected by ring_hi", g, 8);
  endtask

  initial begin
    rst_n = 1'b0; us_tick = 1'b0; cmpl = 1'b0; ring_hi = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_immediate;
    t_burst;
    t_idle;
    t_both;
    t_tick;
    t_zero;
    t_clear;
    t_ring_hi;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule